// File: doc/BRIEF.md
# Serial Presence-Detect Two-Wire Slave

This block is a two-wire (I2C-style) serial slave that answers for a small
identification store on a memory module. The system clock oversamples the
SCL and SDA pins. The slave recognises start and stop conditions and matches
a 7-bit device address. It then either accepts a word pointer followed by
data bytes, or streams bytes out from the pointer for as long as the master
keeps acknowledging.

The store is a 256-byte register array. Reset fills it with a computed
identification pattern. SDA is never driven high: the block only asserts an
enable that pulls the line low, and the board pull-up supplies the high
level. A standby output is high whenever no transfer is open. A master
not-acknowledge during a read parks the slave silently until a stop arrives.

Top module: `spd_slave`

## Requirements
- R1: After reset `standby_o` is 1 and `sda_oe_o` is 0. Store byte k holds (37*k + 11) mod 256.
- R2: Before the first start condition, SCL pulses and SDA changes while SCL is low cause no SDA drive and leave `standby_o` at 1.
- R3: A start condition (SDA falling while SCL is high) clears `standby_o`. A first byte whose bits 7:1 equal the device address 7'h50 is acknowledged, with SDA held low through the ninth SCL pulse. Bit 0 of that byte selects read (1) or write (0).
- R4: A first byte with any other address is not acknowledged, and SDA stays released for every later byte until the next start condition.
- R5: In a write transfer, the slave acknowledges every byte it receives after the address. The first of these bytes loads the word pointer.
- R6: Each later written byte is stored at the word pointer, and the pointer then increments, wrapping from 255 to 0.
- R7: In a read transfer, bytes come from the word pointer, most significant bit first. The slave changes SDA only while SCL is low, and the pointer increments once per byte sent.
- R8: When the master acknowledges a read byte, the slave sends the next sequential byte, wrapping from address 255 to 0.
- R9: After a master not-acknowledge, the slave releases SDA, drives nothing on later SCL pulses and stays out of standby until a stop condition.
- R10: A stop condition (SDA rising while SCL is high) ends any transfer and sets `standby_o` to 1.
- R11: A repeated start inside a transfer returns the slave to address reception without passing through standby. This allows a read to follow a pointer write.
- R12: A read transfer issued without a pointer write starts at the pointer left by the previous transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock pin level |
| sda_i | input | 1 | Serial data pin level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| standby_o | output | 1 | 1 while no transfer is open |

## Verification
A single SDA transition can be either a bus condition or a data bit, depending on the SCL level seen in the same sampled cycle. The condition decoder and the bit shifter therefore compete for the same event. The bench provokes this with repeated starts issued in the middle of transfers, stops after writes, and SDA toggling before any start. It judges the outcome by whether the acknowledges and every returned byte match a bench model of the store and the pointer, and by whether the SDA enable stays silent whenever the model says it must.

// File: rtl/spd_pkg.sv
// Shared types and the reset content function of the presence-detect slave.
// Assumes a store of at most 256 bytes (the pointer is loaded from one byte).
package spd_pkg;

    typedef enum logic [2:0] {
        ST_STANDBY = 3'd0,
        ST_RX      = 3'd1,
        ST_ACK     = 3'd2,
        ST_TX      = 3'd3,
        ST_MACK    = 3'd4,
        ST_HOLD    = 3'd5
    } spd_state_e;

    typedef enum logic [1:0] {
        RX_DEV  = 2'd0,
        RX_WORD = 2'd1,
        RX_DATA = 2'd2
    } spd_rx_kind_e;

    // Identification pattern loaded into byte k at reset.
    function automatic logic [7:0] spd_seed(input int unsigned k);
        int unsigned v;
        v = (k * 37 + 11) % 256;
        return v[7:0];
    endfunction

endpackage

// File: rtl/spd_bus_sync.sv
// Two-wire line conditioner: brings SCL and SDA into the clock domain through
// a flop chain and produces one-cycle event strobes for SCL edges and for
// start / stop conditions. Assumes the bus idles high (chains reset to 1).
module spd_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_q;
    logic              sda_q;

    // Synchronizer chains and one-sample history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_i};
            sda_chain <= {sda_chain[STAGES-2:0], sda_i};
            scl_q     <= scl_chain[STAGES-1];
            sda_q     <= sda_chain[STAGES-1];
        end
    end

    assign scl_s = scl_chain[STAGES-1];
    assign sda_s = sda_chain[STAGES-1];

    // Event decode: SDA moving while SCL stays high is a condition, never data.
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/spd_store.sv
// Byte store for identification data: one write port, one asynchronous read
// port. Reset reloads every byte from spd_seed. Assumes DEPTH is a power of two.
module spd_store
    import spd_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    logic [7:0] words [DEPTH];

    // Reset load of the pattern, single-byte writes afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                words[k] <= spd_seed(k);
            end
        end else if (wr_en) begin
            words[wr_addr] <= wr_data;
        end
    end

    // Read port follows the pointer without delay.
    assign rd_data = words[rd_addr];

endmodule

// File: rtl/spd_ctrl.sv
// Transfer sequencer: address match, pointer load, write, sequential read,
// acknowledge handling and the standby / hold states. Acts only on the event
// strobes from spd_bus_sync. Assumes the strobes are mutually exclusive
// within a cycle, apart from the conditions, which take precedence.
module spd_ctrl
    import spd_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int         DEPTH    = 256,
    localparam int        AW       = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [7:0]    rd_data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic [AW-1:0] ptr,
    output logic          sda_oe,
    output spd_state_e    state_o
);

    spd_state_e   state;
    spd_rx_kind_e kind;
    logic [3:0]   bit_cnt;
    logic [7:0]   sh;
    logic         is_read;
    logic         ack_on;
    logic         mack_ok;
    logic [7:0]   rx_byte;

    // Byte as it stands once the current sample is shifted in.
    assign rx_byte = {sh[6:0], sda_s};

    // Main sequencer: conditions first, then per-state SCL edge handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_STANDBY;
            kind    <= RX_DEV;
            bit_cnt <= '0;
            sh      <= '0;
            is_read <= 1'b0;
            ack_on  <= 1'b0;
            mack_ok <= 1'b0;
            ptr     <= '0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (stop_det) begin
                state  <= ST_STANDBY;
                sda_oe <= 1'b0;
            end else if (start_det) begin
                state   <= ST_RX;
                kind    <= RX_DEV;
                bit_cnt <= '0;
                ack_on  <= 1'b0;
                sda_oe  <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise) begin
                            sh      <= rx_byte;
                            bit_cnt <= bit_cnt + 4'd1;
                            if (bit_cnt == 4'd7) begin
                                ack_on <= 1'b0;
                                case (kind)
                                    RX_DEV: begin
                                        if (rx_byte[7:1] == DEV_ADDR) begin
                                            is_read <= rx_byte[0];
                                            kind    <= RX_WORD;
                                            state   <= ST_ACK;
                                        end else begin
                                            state <= ST_HOLD;
                                        end
                                    end
                                    RX_WORD: begin
                                        ptr   <= rx_byte[AW-1:0];
                                        kind  <= RX_DATA;
                                        state <= ST_ACK;
                                    end
                                    default: begin
                                        wr_en   <= 1'b1;
                                        wr_addr <= ptr;
                                        wr_data <= rx_byte;
                                        ptr     <= ptr + AW'(1);
                                        state   <= ST_ACK;
                                    end
                                endcase
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            if (!ack_on) begin
                                sda_oe <= 1'b1;
                                ack_on <= 1'b1;
                            end else if (is_read) begin
                                sh      <= rd_data;
                                sda_oe  <= ~rd_data[7];
                                ptr     <= ptr + AW'(1);
                                bit_cnt <= '0;
                                state   <= ST_TX;
                            end else begin
                                sda_oe  <= 1'b0;
                                bit_cnt <= '0;
                                state   <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                sda_oe  <= 1'b0;
                                mack_ok <= 1'b0;
                                state   <= ST_MACK;
                            end else begin
                                sda_oe <= ~sh[6];
                                sh     <= {sh[6:0], 1'b0};
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            if (!sda_s) begin
                                mack_ok <= 1'b1;
                            end else begin
                                state <= ST_HOLD;
                            end
                        end else if (scl_fall && mack_ok) begin
                            sh      <= rd_data;
                            sda_oe  <= ~rd_data[7];
                            ptr     <= ptr + AW'(1);
                            bit_cnt <= '0;
                            state   <= ST_TX;
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign state_o = state;

endmodule

// File: rtl/spd_slave.sv
// Top of the presence-detect slave: line conditioner, sequencer and store.
// Assumes an external pull-up on SDA; sda_oe_o only ever pulls the line low.
module spd_slave
    import spd_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         DEPTH       = 256,
    parameter int         SYNC_STAGES = 2,
    localparam int        AW          = $clog2(DEPTH)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o,
    output logic standby_o
);

    logic          scl_s;
    logic          sda_s;
    logic          scl_rise;
    logic          scl_fall;
    logic          start_det;
    logic          stop_det;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic [AW-1:0] ptr;
    logic [7:0]    rd_data;
    spd_state_e    ctrl_state;

    spd_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    spd_ctrl #(.DEV_ADDR(DEV_ADDR), .DEPTH(DEPTH)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ptr       (ptr),
        .sda_oe    (sda_oe_o),
        .state_o   (ctrl_state)
    );

    spd_store #(.DEPTH(DEPTH)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (ptr),
        .rd_data (rd_data)
    );

    // Standby is exactly the idle state of the sequencer.
    assign standby_o = (ctrl_state == ST_STANDBY);

endmodule

// File: rtl/spd_slave_chk.sv
// Protocol checker for spd_slave, attached by bind. Observes the synchronized
// bus, the condition strobes, the sequencer state and the SDA enable.
module spd_slave_chk
    import spd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_oe,
    input logic       standby_o,
    input spd_state_e state
);

    // R7: the SDA enable moves only while SCL is low, except when a condition forces release.
    p_oe_moves_scl_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((sda_oe != $past(sda_oe)) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);

    // R10: a stop always lands in standby.
    p_stop_standby_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> standby_o);

    // R11: a start always returns to address reception.
    p_start_to_rx_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_RX));

    // R1: in standby the line is released.
    p_standby_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        standby_o |-> !sda_oe);

    // R9: the hold state after a not-acknowledge (or mismatch, R4) never drives.
    p_hold_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> !sda_oe);

    // R4: SDA is pulled only while acknowledging or sending data.
    p_drive_states_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state == ST_ACK || state == ST_TX));

endmodule

bind spd_slave spd_slave_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe_o),
    .standby_o (standby_o),
    .state     (ctrl_state)
);

// File: tb/test_spd_slave.sv
// Bench for spd_slave: bit-level two-wire master, byte model of the store.
module test_spd_slave;

    localparam logic [6:0] DEV = 7'h50;
    localparam int Q = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda_low = 1'b0;
    wire  sda_oe;
    wire  standby;
    wire  sda_line = !(m_sda_low || sda_oe);

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    int oe_cnt = 0;
    int scl_hi_moves = 0;
    bit done = 1'b0;
    logic [7:0] model [256];
    int ptr_m = 0;
    logic prev_oe = 1'b0;

    always #2 clk = ~clk;

    spd_slave i_spd_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .sda_oe_o  (sda_oe),
        .standby_o (standby)
    );

    // Monitors sampled on the falling clock edge.
    always @(negedge clk) begin
        if (sda_oe) oe_cnt <= oe_cnt + 1;
        if (rst_n && sda_oe != prev_oe && m_scl) scl_hi_moves <= scl_hi_moves + 1;
        prev_oe <= sda_oe;
    end

    // Watchdog: an expired run is a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !done) begin
            n_errors = n_errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected below 190000", cyc);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    function automatic logic [7:0] seed_of(input int k);
        return 8'((k * 37 + 11) % 256);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_errors = n_errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; idle(Q);
        m_scl = 1'b1; idle(Q);
        m_sda_low = 1'b1; idle(Q);
        m_scl = 1'b0; idle(Q);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; idle(Q);
        m_scl = 1'b1; idle(Q);
        m_sda_low = 1'b0; idle(2 * Q);
    endtask

    task automatic clk_bit(input bit drive_low, output bit seen);
        m_sda_low = drive_low; idle(Q);
        m_scl = 1'b1; idle(Q);
        seen = sda_line;
        m_scl = 1'b0; idle(Q);
    endtask

    task automatic write_byte(input logic [7:0] b, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) clk_bit(!b[i], s);
        clk_bit(1'b0, s);
        ack = !s;
    endtask

    task automatic read_byte(input bit mack, output logic [7:0] d);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b0, s);
            d[i] = s;
        end
        clk_bit(mack, s);
    endtask

    // Pointer write then repeated start and sequential read of n bytes.
    task automatic pointer_read(input int wa, input int n, input string req);
        bit ack;
        logic [7:0] d;
        bus_start();
        write_byte({DEV, 1'b0}, ack);
        check(ack, "R3", ack, 1);
        write_byte(8'(wa), ack);
        check(ack, "R5", ack, 1);
        bus_start();
        check(standby == 1'b0, "R11", standby, 0);
        write_byte({DEV, 1'b1}, ack);
        check(ack, "R11", ack, 1);
        for (int k = 0; k < n; k++) begin
            read_byte(k < n - 1, d);
            check(d == model[(wa + k) % 256], req, d, model[(wa + k) % 256]);
        end
        bus_stop();
        check(standby == 1'b1, "R10", standby, 1);
        ptr_m = (wa + n) % 256;
    endtask

    task automatic seq_write(input int wa, input int n);
        bit ack;
        logic [7:0] d;
        bus_start();
        write_byte({DEV, 1'b0}, ack);
        check(ack, "R3", ack, 1);
        write_byte(8'(wa), ack);
        check(ack, "R5", ack, 1);
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            write_byte(d, ack);
            check(ack, "R5", ack, 1);
            model[(wa + k) % 256] = d;
        end
        bus_stop();
        ptr_m = (wa + n) % 256;
    endtask

    initial begin
        bit ack;
        bit s;
        int snap;
        logic [7:0] d;
        void'($urandom(32'd1645));
        for (int k = 0; k < 256; k++) model[k] = seed_of(k);

        idle(5);
        rst_n = 1'b1;
        idle(5);
        check(standby == 1'b1, "R1 standby", standby, 1);
        check(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);

        // R2: full address byte and ninth pulse with no start before it.
        snap = oe_cnt;
        write_byte({DEV, 1'b0}, ack);
        check(oe_cnt == snap, "R2 drive", oe_cnt - snap, 0);
        check(standby == 1'b1, "R2 standby", standby, 1);

        // R3 / R10: matching address, then stop.
        bus_start();
        check(standby == 1'b0, "R3 standby", standby, 0);
        write_byte({DEV, 1'b0}, ack);
        check(ack, "R3 ack", ack, 1);
        bus_stop();
        check(standby == 1'b1, "R10", standby, 1);

        // R4: foreign address, then more bytes, all unanswered.
        bus_start();
        snap = oe_cnt;
        write_byte({7'h51, 1'b0}, ack);
        check(!ack, "R4 addr", ack, 0);
        write_byte(8'h00, ack);
        check(!ack, "R4 byte", ack, 0);
        check(oe_cnt == snap, "R4 drive", oe_cnt - snap, 0);
        bus_stop();

        // R1 / R7: reset content read from address 0.
        pointer_read(0, 4, "R1 content");

        // R12: current-address read continues at the pointer.
        bus_start();
        write_byte({DEV, 1'b1}, ack);
        check(ack, "R12 ack", ack, 1);
        read_byte(1'b1, d);
        check(d == model[ptr_m], "R12", d, model[ptr_m]);
        read_byte(1'b0, d);
        check(d == model[(ptr_m + 1) % 256], "R12", d, model[(ptr_m + 1) % 256]);
        bus_stop();
        ptr_m = (ptr_m + 2) % 256;

        // R6 / R8: write across the top, read back across it.
        seq_write(254, 3);
        pointer_read(253, 5, "R8 wrap");

        // R9: not-acknowledge, then further clocks stay silent.
        bus_start();
        write_byte({DEV, 1'b1}, ack);
        read_byte(1'b0, d);
        check(d == model[ptr_m], "R7 data", d, model[ptr_m]);
        snap = oe_cnt;
        for (int i = 0; i < 9; i++) clk_bit(1'b0, s);
        check(oe_cnt == snap, "R9 drive", oe_cnt - snap, 0);
        check(standby == 1'b0, "R9 standby", standby, 0);
        bus_stop();
        check(standby == 1'b1, "R10 after R9", standby, 1);
        ptr_m = (ptr_m + 1) % 256;

        // Random mix of writes and pointer reads.
        for (int it = 0; it < 8; it++) begin
            int wa;
            int n;
            wa = int'($urandom % 256);
            n = 1 + int'($urandom % 6);
            seq_write(wa, n);
            pointer_read(int'($urandom % 256), 1 + int'($urandom % 6), "R6 random");
        end

        check(scl_hi_moves == 0, "R7 sda while scl high", scl_hi_moves, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule